// File: doc/BRIEF.md
# Nibble-Immediate Register File

This block holds the programmer-visible state of a small 8-bit processor whose instructions are all single bytes: two 8-bit data registers (A and B), two 16-bit address pointers (P0 and P1) and a 16-bit stack pointer. No instruction has operand bytes. Constants therefore arrive four bits at a time, inside the opcode itself. The block decodes the immediate-load half of the opcode space and deposits the carried value into one nibble of the chosen register. All other nibbles keep their contents.

Beside the immediate path, the block offers a plain write port for moves and pops, and increment and decrement strobes on the stack pointer for push and pop. It also offers a selectable read port and direct views of every register. The ALU, memory sequencing and the rest of instruction decode sit outside this block.

Top module: `nibreg_file`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears A, B, P0, P1 and SP to zero.
- R2: When `op_valid` is high and `op_byte[7]` is 1, `op_byte[6:4]` selects the target and `op_byte[3:0]` is written there at the clock edge. The targets are: 0 = A bits 3:0, 1 = A bits 7:4, 2 = B bits 3:0, 3 = B bits 7:4, and 4, 5, 6, 7 = P0 bits 3:0, 7:4, 11:8, 15:12. The new value is visible on the outputs after that edge.
- R3: An immediate load changes only the addressed 4 bits. The other bits of that register and all other registers keep their values unless another port writes them.
- R4: An opcode with `op_byte[7]` = 0, or any opcode while `op_valid` is low, changes no register.
- R5: With `wr_en` high, `wr_data` is written at the clock edge to the register chosen by `wr_sel`: 0 = A, 1 = B (both take `wr_data[7:0]`), 2 = P0, 3 = P1, 4 = SP. Codes 5 to 7 write nothing.
- R6: If an immediate load and a plain write target the same register in the same cycle, the immediate load is applied and the plain write is dropped for that register. When they target different registers, both take effect.
- R7: `sp_inc` alone adds 1 to SP and wraps 0xFFFF to 0x0000. `sp_dec` alone subtracts 1 and wraps 0x0000 to 0xFFFF. Both together leave SP unchanged.
- R8: A plain write to SP (`wr_sel` = 4) overrides `sp_inc` and `sp_dec` in the same cycle.
- R9: `rd_data` combinationally returns the register chosen by `rd_sel`, using the `wr_sel` codes. A and B are zero-extended to 16 bits. Codes 5 to 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Opcode byte is present this cycle |
| op_byte | input | 8 | Current one-byte opcode |
| wr_en | input | 1 | Plain write enable |
| wr_sel | input | 3 | Plain write target code |
| wr_data | input | 16 | Plain write value |
| sp_inc | input | 1 | Stack pointer increment strobe |
| sp_dec | input | 1 | Stack pointer decrement strobe |
| rd_sel | input | 3 | Read port register code |
| rd_data | output | 16 | Read port value |
| reg_a | output | 8 | Data register A |
| reg_b | output | 8 | Data register B |
| ptr0 | output | 16 | Address pointer P0 |
| ptr1 | output | 16 | Address pointer P1 |
| sp | output | 16 | Stack pointer |

## Verification
Every register is driven straight to a port, so a wrong bit of state appears on the outputs in the cycle right after the edge that stored it. The bench compares all five registers and the read port against its own model on every cycle. A misplaced nibble, a lost wrap or a wrong priority therefore shows up one cycle after the stimulus that caused it. Random opcodes, writes and strobes run alongside directed cases: wrap at both ends of SP, strobe collisions, same-register port conflicts, non-load opcodes and unused select codes.

// File: rtl/nibreg_file.sv
module nibreg_file #(
  parameter int DW = 8,
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          op_valid,
  input  logic [7:0]    op_byte,
  input  logic          wr_en,
  input  logic [2:0]    wr_sel,
  input  logic [AW-1:0] wr_data,
  input  logic          sp_inc,
  input  logic          sp_dec,
  input  logic [2:0]    rd_sel,
  output logic [AW-1:0] rd_data,
  output logic [DW-1:0] reg_a,
  output logic [DW-1:0] reg_b,
  output logic [AW-1:0] ptr0,
  output logic [AW-1:0] ptr1,
  output logic [AW-1:0] sp
);
  localparam int NB = 4;
  localparam logic [2:0] S_A = 3'd0, S_B = 3'd1, S_P0 = 3'd2, S_P1 = 3'd3, S_SP = 3'd4;

  logic          imm, imm_a, imm_b, imm_p;
  logic [2:0]    tgt;
  logic [NB-1:0] val;
  logic          wa, wb, wp0, wp1, wsp;

  assign imm   = op_valid & op_byte[7];
  assign tgt   = op_byte[6:4];
  assign val   = op_byte[3:0];
  assign imm_a = imm & (tgt[2:1] == 2'b00);
  assign imm_b = imm & (tgt[2:1] == 2'b01);
  assign imm_p = imm & tgt[2];
  assign wa    = wr_en & (wr_sel == S_A);
  assign wb    = wr_en & (wr_sel == S_B);
  assign wp0   = wr_en & (wr_sel == S_P0);
  assign wp1   = wr_en & (wr_sel == S_P1);
  assign wsp   = wr_en & (wr_sel == S_SP);

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_a <= '0;
      reg_b <= '0;
      ptr0  <= '0;
      ptr1  <= '0;
      sp    <= '0;
    end else begin
      if (imm_a)   reg_a[{tgt[0], 2'b00} +: NB] <= val;
      else if (wa) reg_a <= wr_data[DW-1:0];
      if (imm_b)   reg_b[{tgt[0], 2'b00} +: NB] <= val;
      else if (wb) reg_b <= wr_data[DW-1:0];
      if (imm_p)    ptr0[{tgt[1:0], 2'b00} +: NB] <= val;
      else if (wp0) ptr0 <= wr_data;
      if (wp1) ptr1 <= wr_data;
      if (wsp)                  sp <= wr_data;
      else if (sp_inc & ~sp_dec) sp <= sp + 1'b1;
      else if (sp_dec & ~sp_inc) sp <= sp - 1'b1;
    end
  end

  always_comb begin
    case (rd_sel)
      S_A:     rd_data = AW'(reg_a);
      S_B:     rd_data = AW'(reg_b);
      S_P0:    rd_data = ptr0;
      S_P1:    rd_data = ptr1;
      S_SP:    rd_data = sp;
      default: rd_data = '0;
    endcase
  end

  // R1
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (reg_a == '0 && reg_b == '0 && ptr0 == '0 && ptr1 == '0 && sp == '0));
  // R2
  a_r2_low_nibble_a: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_byte[7:4] == 4'b1000) |=> reg_a[3:0] == $past(op_byte[3:0]));
  // R3
  a_r3_high_nibble_kept: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_byte[7:4] == 4'b1000) |=> reg_a[DW-1:4] == $past(reg_a[DW-1:4]));
  // R4
  a_r4_idle_stable: assert property (@(posedge clk) disable iff (rst)
    (!(op_valid && op_byte[7]) && !wr_en && !sp_inc && !sp_dec) |=>
      ($stable(reg_a) && $stable(reg_b) && $stable(ptr0) && $stable(ptr1) && $stable(sp)));
  // R7
  a_r7_dec_wrap: assert property (@(posedge clk) disable iff (rst)
    (sp_dec && !sp_inc && !(wr_en && wr_sel == S_SP) && sp == '0) |=> sp == {AW{1'b1}});
  // R8
  a_r8_write_beats_strobe: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == S_SP) |=> sp == $past(wr_data));
endmodule

// File: tb/sim_nibreg_file.sv
`timescale 1ns/1ps
module sim_nibreg_file;
  logic        clk = 0, rst = 1;
  logic        op_valid = 0, wr_en = 0, sp_inc = 0, sp_dec = 0;
  logic [7:0]  op_byte = 0;
  logic [2:0]  wr_sel = 0, rd_sel = 0;
  logic [15:0] wr_data = 0, rd_data, ptr0, ptr1, sp;
  logic [7:0]  reg_a, reg_b;
  logic [7:0]  ma, mb;
  logic [15:0] mp0, mp1, msp;
  int checks = 0, fails = 0, cyc = 0;

  nibreg_file u0 (.clk, .rst, .op_valid, .op_byte, .wr_en, .wr_sel, .wr_data,
                  .sp_inc, .sp_dec, .rd_sel, .rd_data, .reg_a, .reg_b, .ptr0, .ptr1, .sp);

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] exp_rd(logic [2:0] s);
    case (s)
      3'd0: return {8'h0, ma};
      3'd1: return {8'h0, mb};
      3'd2: return mp0;
      3'd3: return mp1;
      3'd4: return msp;
      default: return 16'h0;
    endcase
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk(tag, {8'h0, reg_a}, {8'h0, ma});
    chk(tag, {8'h0, reg_b}, {8'h0, mb});
    chk(tag, ptr0, mp0);
    chk(tag, ptr1, mp1);
    chk(tag, sp, msp);
    chk("R9 read port", rd_data, exp_rd(rd_sel));
  endtask

  task automatic model_step();
    logic ia, ib, ip;
    logic [3:0] v;
    v  = op_byte[3:0];
    ia = op_valid && op_byte[7] && op_byte[6:5] == 2'b00;
    ib = op_valid && op_byte[7] && op_byte[6:5] == 2'b01;
    ip = op_valid && op_byte[7] && op_byte[6];
    if (ia) begin if (op_byte[4]) ma[7:4] = v; else ma[3:0] = v; end
    else if (wr_en && wr_sel == 0) ma = wr_data[7:0];
    if (ib) begin if (op_byte[4]) mb[7:4] = v; else mb[3:0] = v; end
    else if (wr_en && wr_sel == 1) mb = wr_data[7:0];
    if (ip) case (op_byte[5:4])
      2'd0: mp0[3:0] = v;
      2'd1: mp0[7:4] = v;
      2'd2: mp0[11:8] = v;
      default: mp0[15:12] = v;
    endcase
    else if (wr_en && wr_sel == 2) mp0 = wr_data;
    if (wr_en && wr_sel == 3) mp1 = wr_data;
    if (wr_en && wr_sel == 4) msp = wr_data;
    else if (sp_inc && !sp_dec) msp = msp + 16'd1;
    else if (sp_dec && !sp_inc) msp = msp - 16'd1;
  endtask

  task automatic cycle(logic ov, logic [7:0] ob, logic we, logic [2:0] ws,
                       logic [15:0] wd, logic inc, logic dec, logic [2:0] rs, string tag);
    op_valid = ov; op_byte = ob; wr_en = we; wr_sel = ws; wr_data = wd;
    sp_inc = inc; sp_dec = dec; rd_sel = rs;
    model_step();
    @(negedge clk);
    check_all(tag);
  endtask

  initial begin
    void'($urandom(32'd2024));
    ma = 8'h5A; mb = 8'h5A; mp0 = 16'h5A5A; mp1 = 16'h5A5A; msp = 16'h5A5A;
    repeat (2) @(negedge clk);
    ma = 0; mb = 0; mp0 = 0; mp1 = 0; msp = 0;
    rst = 0;
    check_all("R1 reset state");
    // R7 wrap down, wrap up, both strobes
    cycle(0, 0, 0, 0, 0, 0, 1, 4, "R7 dec wrap from 0");
    cycle(0, 0, 0, 0, 0, 1, 0, 4, "R7 inc wrap from FFFF");
    cycle(0, 0, 0, 0, 0, 1, 1, 4, "R7 both strobes hold");
    // R8 write beats strobes
    cycle(0, 0, 1, 4, 16'h1234, 1, 0, 4, "R8 write over inc");
    cycle(0, 0, 1, 4, 16'h0000, 0, 1, 4, "R8 write over dec");
    // R2 every target
    for (int t = 0; t < 8; t++) cycle(1, {1'b1, 3'(t), 4'(t + 9)}, 0, 0, 0, 0, 0, 3'(t / 2 > 1 ? 2 : t / 2), "R2 nibble load");
    // R3 neighbour untouched
    cycle(1, 8'hA3, 0, 0, 0, 0, 0, 1, "R3 B low only");
    // R4 ignored opcodes
    cycle(1, 8'h7F, 0, 0, 0, 0, 0, 0, "R4 bit7 clear");
    cycle(0, 8'hFF, 0, 0, 0, 0, 0, 2, "R4 op_valid low");
    // R5 plain writes, unused codes
    cycle(0, 0, 1, 3, 16'hBEEF, 0, 0, 3, "R5 write P1");
    cycle(0, 0, 1, 0, 16'hFFC3, 0, 0, 0, "R5 write A low byte");
    cycle(0, 0, 1, 6, 16'hDEAD, 0, 0, 6, "R5 unused code");
    // R6 conflicts
    cycle(1, 8'h9E, 1, 0, 16'h0011, 0, 0, 0, "R6 same reg imm wins");
    cycle(1, 8'hC7, 1, 1, 16'h0022, 0, 0, 1, "R6 different regs both");
    // R9 unused read codes
    cycle(0, 0, 0, 0, 0, 0, 0, 5, "R9 code 5");
    cycle(0, 0, 0, 0, 0, 0, 0, 7, "R9 code 7");
    // random mix: R2 R3 R5 R6 R7 R8
    for (int i = 0; i < 3000; i++)
      cycle($urandom_range(0, 3) != 0, 8'($urandom), $urandom_range(0, 2) == 0,
            3'($urandom), 16'($urandom), $urandom_range(0, 3) == 0,
            $urandom_range(0, 3) == 0, 3'($urandom), "R2 R3 R5 R6 R7 R8 random");
    // R1 reset mid-run
    rst = 1; op_valid = 0; wr_en = 0; sp_inc = 0; sp_dec = 0;
    @(negedge clk);
    ma = 0; mb = 0; mp0 = 0; mp1 = 0; msp = 0;
    rst = 0;
    check_all("R1 reset after traffic");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait (cyc > 100000);
    checks++; fails++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule